// File: doc/BRIEF.md
# Binarized Matrix-Vector Threshold Layer

This block computes one layer of a network whose weights and activations are single bits. An input activation vector of `MAT_W` bits arrives on a ready/valid stream, `SIMD` bits per word. Each of `PE` lanes works out how many positions of a stored weight row agree with the activation bits; this is an XNOR followed by a count of ones. The lane adds these partial counts over the input words of the vector. It then compares the total with a stored threshold for that neuron, and the result becomes the neuron's output bit.

The `MAT_H` neurons are spread across the lanes, and the lanes work through them in `MAT_H/PE` passes over the same vector. The first pass computes straight from the incoming stream and also keeps a copy of each word in a small buffer; the later passes read that buffer. Each pass produces one `PE`-bit output word. Words leave in neuron order, so the output can feed the next layer through a plain FIFO. Weights and thresholds sit in per-lane local memories. A simple write port loads them before operation.

Top module: `xnor_thresh_layer`

## Requirements
- R1: For neuron j, the agreement count is the number of indices i in 0..MAT_W-1 where weight bit (j,i) equals input element i. This count equals (dot+MAT_W)/2, where dot is the ±1 dot product of the weight row and the input vector.
- R2: A neuron's output bit is 1 when its agreement count is greater than or equal to its stored threshold, and 0 otherwise. A threshold of 0 always gives 1. A threshold of MAT_W gives 1 only on a full match.
- R3: Output words are numbered k = 0..MAT_H/PE-1 within a vector. Bit p of word k is the output of neuron k*PE+p, and the words leave in rising k order.
- R4: Each vector yields exactly MAT_H/PE output words. out_valid rises only after the final input chunk of a pass has been processed.
- R5: A vector is taken as MAT_W/SIMD input words. Bit i of word s is input element s*SIMD+i. After the last word of a vector is accepted, in_ready stays low until the last pass over that vector has run.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. No result is lost or repeated.
- R7: A weight write with wt_lane=p and wt_addr=n*(MAT_W/SIMD)+s stores the bits of neuron n*PE+p for input elements s*SIMD+i, where i is the bit index in wt_data.
- R8: A threshold write with th_lane=p and th_addr=n stores the threshold of neuron n*PE+p.
- R9: After reset, out_valid is 0 and in_ready is 1.
- R10: Accumulation restarts for every neuron and every vector. A vector sent right after another gives results that depend only on the new vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight memory write strobe |
| wt_lane | input | PE_W | Lane chosen for the weight write |
| wt_addr | input | WA_W | Weight row address, fold*(MAT_W/SIMD)+chunk |
| wt_data | input | SIMD | Weight bits to write |
| th_we | input | 1 | Threshold memory write strobe |
| th_lane | input | PE_W | Lane chosen for the threshold write |
| th_addr | input | NA_W | Neuron fold index |
| th_data | input | ACC_W | Threshold value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | SIMD | Input activation chunk |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take the output word |
| out_data | output | PE | Output neuron bits of one fold |

## Verification
The layer is tried with all-zero, all-one and alternating input vectors against random weights. These show whether the XNOR inverts the right operand, since zeros and ones must give mirror-image counts. Random vectors with idle gaps and random stall patterns on the output separate correct pass sequencing from a design that only works when data flows every cycle. In threshold edge tests, every threshold is 0, or every threshold is MAT_W with the input equal to one chosen weight row. These show off-by-one errors in the comparison and in the ordering of lanes and folds. Consecutive vectors with opposite contents show whether any count carries over from one vector to the next.

// File: rtl/mvtu_pkg.sv
package mvtu_pkg;

  // number of set bits in a word of up to 32 bits
  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 32; i++) c += 32'(v[i]);
    return c;
  endfunction

  // neuron fires when agreement count reaches its threshold
  function automatic logic meets(input int unsigned sum, input int unsigned thr);
    return sum >= thr;
  endfunction

endpackage

// File: rtl/mvtu_seq.sv
module mvtu_seq #(
  parameter int SF   = 4,
  parameter int NF   = 4,
  parameter int SA_W = 2,
  parameter int NA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic            in_ready,
  output logic            step,
  output logic            first,
  output logic            last,
  output logic            live,
  output logic [NA_W-1:0] nf,
  output logic [SA_W-1:0] sf,
  output logic            out_valid
);
  logic out_free;
  logic src_ok;

  assign out_free = !out_valid || out_ready;
  assign live     = (nf == '0);
  assign src_ok   = live ? in_valid : 1'b1;
  assign step     = src_ok && out_free;
  assign in_ready = live && out_free;
  assign first    = (sf == '0);
  assign last     = (sf == SA_W'(SF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nf        <= '0;
      sf        <= '0;
      out_valid <= 1'b0;
    end else begin
      if (step) begin
        if (last) begin
          sf <= '0;
          nf <= (nf == NA_W'(NF - 1)) ? '0 : nf + 1'b1;
        end else begin
          sf <= sf + 1'b1;
        end
      end
      if (step && last)   out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mvtu_inbuf.sv
module mvtu_inbuf #(
  parameter int SIMD = 4,
  parameter int SF   = 4,
  parameter int SA_W = 2
) (
  input  logic            clk,
  input  logic            wr,
  input  logic            live,
  input  logic [SA_W-1:0] sf,
  input  logic [SIMD-1:0] in_data,
  output logic [SIMD-1:0] act
);
  logic [SIMD-1:0] vec_q [SF];

  always_ff @(posedge clk) begin
    if (wr) vec_q[sf] <= in_data;
  end

  // first pass uses the stream directly, later passes replay the copy
  assign act = live ? in_data : vec_q[sf];
endmodule

// File: rtl/mvtu_lane.sv
module mvtu_lane #(
  parameter int SIMD  = 4,
  parameter int SF    = 4,
  parameter int NF    = 4,
  parameter int ACC_W = 5,
  parameter int SA_W  = 2,
  parameter int NA_W  = 2,
  parameter int WA_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wt_we,
  input  logic [WA_W-1:0]  wt_addr,
  input  logic [SIMD-1:0]  wt_data,
  input  logic             th_we,
  input  logic [NA_W-1:0]  th_addr,
  input  logic [ACC_W-1:0] th_data,
  input  logic             step,
  input  logic             first,
  input  logic [NA_W-1:0]  nf,
  input  logic [SA_W-1:0]  sf,
  input  logic [SIMD-1:0]  act,
  output logic             hit,
  output logic [ACC_W-1:0] acc_o
);
  logic [SIMD-1:0]  wmem [NF*SF];
  logic [ACC_W-1:0] tmem [NF];
  logic [WA_W-1:0]  rd_addr;
  logic [SIMD-1:0]  wrow;
  logic [SIMD-1:0]  agree;
  logic [ACC_W-1:0] part;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (wt_we) wmem[wt_addr] <= wt_data;
    if (th_we) tmem[th_addr] <= th_data;
  end

  assign rd_addr = WA_W'(int'(nf) * SF + int'(sf));
  assign wrow    = wmem[rd_addr];
  assign agree   = ~(wrow ^ act);
  assign part    = ACC_W'(mvtu_pkg::ones32(32'(agree)));
  assign base    = first ? '0 : acc_q;
  assign sum     = base + part;
  assign hit     = mvtu_pkg::meets(32'(sum), 32'(tmem[nf]));
  assign acc_o   = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= sum;
  end
endmodule

// File: rtl/xnor_thresh_layer.sv
module xnor_thresh_layer #(
  parameter int MAT_W = 16,
  parameter int MAT_H = 8,
  parameter int SIMD  = 4,
  parameter int PE    = 2,
  localparam int SF    = MAT_W / SIMD,
  localparam int NF    = MAT_H / PE,
  localparam int ACC_W = $clog2(MAT_W + 1),
  localparam int SA_W  = (SF > 1) ? $clog2(SF) : 1,
  localparam int NA_W  = (NF > 1) ? $clog2(NF) : 1,
  localparam int WA_W  = (NF * SF > 1) ? $clog2(NF * SF) : 1,
  localparam int PE_W  = (PE > 1) ? $clog2(PE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wt_we,
  input  logic [PE_W-1:0]  wt_lane,
  input  logic [WA_W-1:0]  wt_addr,
  input  logic [SIMD-1:0]  wt_data,
  input  logic             th_we,
  input  logic [PE_W-1:0]  th_lane,
  input  logic [NA_W-1:0]  th_addr,
  input  logic [ACC_W-1:0] th_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SIMD-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PE-1:0]    out_data
);
  if (MAT_W % SIMD != 0) begin : g_bad_w
    $error("MAT_W must be a multiple of SIMD");
  end
  if (MAT_H % PE != 0) begin : g_bad_h
    $error("MAT_H must be a multiple of PE");
  end
  if (SIMD > 32) begin : g_bad_simd
    $error("SIMD above 32 is not supported");
  end

  logic                step;
  logic                first;
  logic                last;
  logic                live;
  logic [NA_W-1:0]     nf;
  logic [SA_W-1:0]     sf;
  logic [SIMD-1:0]     act;
  logic [PE-1:0]       hits;
  logic [PE*ACC_W-1:0] acc_all;
  logic [PE-1:0]       out_q;

  mvtu_seq #(.SF(SF), .NF(NF), .SA_W(SA_W), .NA_W(NA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .step(step), .first(first), .last(last),
    .live(live), .nf(nf), .sf(sf), .out_valid(out_valid)
  );

  mvtu_inbuf #(.SIMD(SIMD), .SF(SF), .SA_W(SA_W)) u_buf (
    .clk(clk), .wr(step && live), .live(live), .sf(sf),
    .in_data(in_data), .act(act)
  );

  for (genvar p = 0; p < PE; p++) begin : g_lane
    mvtu_lane #(
      .SIMD(SIMD), .SF(SF), .NF(NF), .ACC_W(ACC_W),
      .SA_W(SA_W), .NA_W(NA_W), .WA_W(WA_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .wt_we(wt_we && (wt_lane == PE_W'(p))), .wt_addr(wt_addr), .wt_data(wt_data),
      .th_we(th_we && (th_lane == PE_W'(p))), .th_addr(th_addr), .th_data(th_data),
      .step(step), .first(first), .nf(nf), .sf(sf), .act(act),
      .hit(hits[p]), .acc_o(acc_all[p*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             out_q <= '0;
    else if (step && last)  out_q <= hits;
  end

  assign out_data = out_q;
endmodule

// File: rtl/mvtu_chk.sv
module mvtu_chk #(
  parameter int MAT_W = 16,
  parameter int PE    = 2,
  parameter int NF    = 4,
  parameter int ACC_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [PE-1:0]       out_data,
  input logic                step,
  input logic                last,
  input logic                live,
  input logic [PE*ACC_W-1:0] acc_all
);
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  a_r4_rise_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(step && last));

  a_r4_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(step && last)) |=> !out_valid);

  if (NF > 1) begin : g_reuse
    a_r5_no_input_in_reuse: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && live) |=> !in_ready);
  end

  for (genvar p = 0; p < PE; p++) begin : g_acc
    a_r10_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      acc_all[p*ACC_W +: ACC_W] <= ACC_W'(MAT_W));
  end
endmodule

bind xnor_thresh_layer mvtu_chk #(
  .MAT_W(MAT_W), .PE(PE), .NF(NF), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .step(step), .last(last),
  .live(live), .acc_all(acc_all)
);

// File: tb/xnor_thresh_layer_tb.sv
`timescale 1ns/1ps
module xnor_thresh_layer_tb;
  localparam int MAT_W = 16;
  localparam int MAT_H = 8;
  localparam int SIMD  = 4;
  localparam int PE    = 2;
  localparam int SF    = MAT_W / SIMD;
  localparam int NF    = MAT_H / PE;
  localparam int ACC_W = $clog2(MAT_W + 1);
  localparam int NA_W  = $clog2(NF);
  localparam int WA_W  = $clog2(NF * SF);
  localparam int PE_W  = $clog2(PE);

  logic clk = 0;
  logic rst_n = 0;
  logic wt_we = 0;
  logic [PE_W-1:0] wt_lane = '0;
  logic [WA_W-1:0] wt_addr = '0;
  logic [SIMD-1:0] wt_data = '0;
  logic th_we = 0;
  logic [PE_W-1:0] th_lane = '0;
  logic [NA_W-1:0] th_addr = '0;
  logic [ACC_W-1:0] th_data = '0;
  logic in_valid = 0;
  logic in_ready;
  logic [SIMD-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [PE-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int got = 0;
  bit drv_done = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [MAT_W-1:0] wrow [MAT_H];
  int thr [MAT_H];

  always #2.5 clk = ~clk;

  xnor_thresh_layer #(.MAT_W(MAT_W), .MAT_H(MAT_H), .SIMD(SIMD), .PE(PE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wt_we(wt_we), .wt_lane(wt_lane), .wt_addr(wt_addr), .wt_data(wt_data),
    .th_we(th_we), .th_lane(th_lane), .th_addr(th_addr), .th_data(th_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // agreement count recovered from the +/-1 dot product
  function automatic int ref_pop(logic [MAT_W-1:0] v, logic [MAT_W-1:0] w);
    int dot = 0;
    for (int i = 0; i < MAT_W; i++) begin
      dot += (v[i] ? 1 : -1) * (w[i] ? 1 : -1);
    end
    return (dot + MAT_W) / 2;
  endfunction

  function automatic logic [PE-1:0] exp_word(logic [MAT_W-1:0] v, int k);
    logic [PE-1:0] e;
    for (int p = 0; p < PE; p++) e[p] = (ref_pop(v, wrow[k*PE+p]) >= thr[k*PE+p]);
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_weights();
    for (int n = 0; n < NF; n++)
      for (int p = 0; p < PE; p++)
        for (int s = 0; s < SF; s++) begin
          @(negedge clk);
          wt_we = 1; wt_lane = PE_W'(p); wt_addr = WA_W'(n*SF+s);
          wt_data = wrow[n*PE+p][s*SIMD +: SIMD];
        end
    @(negedge clk) wt_we = 0;
  endtask

  task automatic load_thr();
    for (int n = 0; n < NF; n++)
      for (int p = 0; p < PE; p++) begin
        @(negedge clk);
        th_we = 1; th_lane = PE_W'(p); th_addr = NA_W'(n);
        th_data = ACC_W'(thr[n*PE+p]);
      end
    @(negedge clk) th_we = 0;
  endtask

  task automatic drive(logic [MAT_W-1:0] v, bit gap);
    for (int s = 0; s < SF; s++) begin
      if (gap) begin
        @(negedge clk) in_valid = 0;
      end
      @(negedge clk);
      in_valid = 1; in_data = v[s*SIMD +: SIMD];
      #1;
      while (!in_ready) begin
        @(negedge clk); #1;
      end
    end
    @(negedge clk) in_valid = 0;
    drv_done = 1;
  endtask

  task automatic collect(logic [MAT_W-1:0] v, bit stall, string tag);
    int cyc = 0;
    bit pend = 0;
    logic [PE-1:0] held = '0;
    while (got < NF) begin
      @(negedge clk);
      out_ready = stall ? (cyc % 3 == 2) : 1'b1;
      cyc++;
      #1;
      if (pend) check(out_valid && out_data == held, "R6 hold", 32'(out_data), 32'(held));
      pend = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        check(out_data == exp_word(v, got), {"R1/R2/R3 ", tag},
              32'(out_data), 32'(exp_word(v, got)));
        got++;
      end
    end
  endtask

  task automatic watch_reuse(output int viol);
    viol = 0;
    while (got < NF) begin
      @(negedge clk); #2;
      if (drv_done && got < NF - 1 && in_ready) viol++;
    end
  endtask

  task automatic run_vec(logic [MAT_W-1:0] v, bit gap, bit stall, string tag);
    int viol;
    got = 0; drv_done = 0;
    fork
      drive(v, gap);
      collect(v, stall, tag);
      watch_reuse(viol);
    join
    check(viol == 0, "R5 in_ready low during reuse passes", 32'(viol), 0);
    @(negedge clk); out_ready = 1; #1;
    check(!out_valid, "R4 no extra output word", 32'(out_valid), 0);
  endtask

  task automatic t_reset();
    check(!out_valid, "R9 out_valid after reset", 32'(out_valid), 0);
    check(in_ready, "R9 in_ready after reset", 32'(in_ready), 1);
  endtask

  task automatic t_patterns();
    for (int j = 0; j < MAT_H; j++) begin
      wrow[j] = MAT_W'(rnd());
      thr[j]  = 4 + j;
    end
    load_weights(); load_thr();
    run_vec('0, 0, 0, "R1 zeros");
    run_vec('1, 0, 0, "R1 ones");
    run_vec({(MAT_W/2){2'b10}}, 0, 0, "R1 alternating");
  endtask

  task automatic t_gaps();
    for (int r = 0; r < 3; r++) run_vec(MAT_W'(rnd()), 1, 0, "R5 gaps");
  endtask

  task automatic t_stall();
    for (int r = 0; r < 3; r++) run_vec(MAT_W'(rnd()), r[0], 1, "R6 stall");
  endtask

  task automatic t_thr_edges();
    for (int j = 0; j < MAT_H; j++) thr[j] = 0;
    load_thr();
    run_vec(MAT_W'(rnd()), 0, 0, "R2 threshold zero");
    for (int j = 0; j < MAT_H; j++) thr[j] = MAT_W;
    load_thr();
    run_vec(wrow[3], 0, 0, "R2 threshold full");
    run_vec(wrow[3] ^ 16'h0100, 0, 0, "R2 one bit short");
  endtask

  task automatic t_order();
    for (int j = 0; j < MAT_H; j++) begin
      wrow[j] = MAT_W'(16'h0F0F ^ (16'h0001 << j) ^ (16'h8000 >> j));
      thr[j]  = MAT_W;
    end
    load_weights(); load_thr();
    for (int m = 0; m < MAT_H; m += 3) run_vec(wrow[m], 0, 0, "R7 R8 R3 row order");
  endtask

  task automatic t_back_to_back();
    for (int j = 0; j < MAT_H; j++) thr[j] = MAT_W / 2 + 1;
    load_thr();
    run_vec('1, 0, 0, "R10 first");
    run_vec('0, 0, 0, "R10 second");
    run_vec({(MAT_W/4){4'b1100}}, 0, 1, "R10 third");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk) #1;
    t_reset();
    t_patterns();
    t_gaps();
    t_stall();
    t_thr_edges();
    t_order();
    t_back_to_back();
    finish_run();
  end
endmodule